// File: doc/BRIEF.md
# Event Timer Register Block with Main Counter

This block is the register front end of a multi-channel event timer. It decodes a 1 KiB window of 32-bit words on a small valid/ready register bus. It also holds the 64-bit main counter that the comparator channels compare against. The window has these registers:

- a read-only capability pair;
- a global configuration word with an enable bit and a legacy-routing bit;
- a write-one-to-clear interrupt status word;
- the counter, split into two 32-bit halves;
- one register group per timer channel, holding its configuration, comparator and message-route words.

The comparator channels and the interrupt router are separate blocks. They read the exported registers, raise `evt_fire` when a channel expires, and react to the `status_clr` and `cancel_all` pulses.

A small state machine drives each bus transaction. **ST_IDLE** is the only state with `req_ready` high. An accepted read moves to **ST_READ** (the *accept-read* transition). An accepted write moves to **ST_WRITE** (the *accept-write* transition). Both states present `rsp_valid` for exactly one cycle and return unconditionally to ST_IDLE (the *complete* transition). The write takes effect on the clock edge that leaves ST_WRITE. Read data is formed from the register state during the ST_READ cycle.

Top module: `evt_timer_regs`

## Requirements
- R1: Only word-aligned addresses (req_addr[1:0] = 0) reach a register. Misaligned or unmapped offsets read as 0, and writes to them change nothing. Offset 0x014 always reads 0.
- R2: `req_ready` is high only in ST_IDLE. Every accepted request yields `rsp_valid` for exactly one cycle, in the cycle after acceptance, together with the read data.
- R3: Offset 0x000 reads 0x8086A001 with (NUM_TIMERS−1) OR-ed into bits 12:8. Offset 0x004 reads TICK_PERIOD. Writes to both offsets are ignored.
- R4: Offset 0x010 is the global configuration word: bit 0 is the enable, bit 1 is legacy routing, and all other bits read 0. It resets to 0 and drives `tmr_enable` and `legacy_route`.
- R5: The counter resets to 0. It advances by exactly 1 per clock while the enable is set, and holds its value while the enable is clear.
- R6: A write to 0x0F0 replaces the low half of the counter, and a write to 0x0F4 replaces the high half. The other half keeps its value. The write is accepted whether or not counting is enabled. The counter does not advance on the edge of the write.
- R7: A read of 0x0F0 captures the high half into a shadow register. The next read of 0x0F4 returns that captured value and releases the shadow. A read of 0x0F4 with no capture pending returns the live high half.
- R8: Offset 0x020 holds one status bit per timer. Bits are set by `evt_fire`. A write clears only the bits that are 1 in both the data and the current status, and `status_clr` pulses those bits in the write cycle. If a set and a clear hit the same bit on the same edge, the set wins.
- R9: A write that changes the enable from 1 to 0 pulses `cancel_all` in the write cycle and clears the whole status word.
- R10: Timer n occupies 0x100 + 0x20·n. The words in each group are:
  - +0x00: configuration. Only the bits in mask 0x00007F4E are writable. Bits 4 and 5 read 1. The reset value is 0x00000030.
  - +0x04: reads ROUTE_CAP and ignores writes.
  - +0x08 and +0x0C: comparator low and high halves, reset to all ones.
  - +0x10 and +0x14: route low and high halves, reset to 0.
  - +0x18 and +0x1C: read 0.

  The registers appear on `tmr_cfg`, `tmr_cmp` and `tmr_route`, with timer n at slice n.
- R11: A timer group whose index is NUM_TIMERS or above reads 0, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte offset in the window |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request accepted this cycle |
| rsp_valid | output | 1 | Response cycle |
| rsp_rdata | output | 32 | Read data, valid with rsp_valid |
| evt_fire | input | NUM_TIMERS | Channel expiry, sets status bits |
| cnt_value | output | 64 | Main counter |
| tmr_enable | output | 1 | Global enable |
| legacy_route | output | 1 | Legacy routing select |
| irq_status | output | NUM_TIMERS | Status word |
| status_clr | output | NUM_TIMERS | Status bits cleared by the current write |
| cancel_all | output | 1 | Global disable pulse to all channels |
| tmr_cfg | output | 32·NUM_TIMERS | Timer configuration low words |
| tmr_cmp | output | 64·NUM_TIMERS | Timer comparators |
| tmr_route | output | 64·NUM_TIMERS | Timer message-route words |

## Verification
The checker watches the following on every cycle:

- the single-cycle response and the return to ready;
- the counter advancing by one or holding still, according to the enable, except on edges where the counter is written;
- status bits cleared by a write staying cleared unless a fire arrives on the same edge;
- the disable pulse leaving both the enable and the status at zero.

The address decode, the write masks, the capability contents, the shadow behaviour across a low-half wrap, and the out-of-range timer groups can only be shown by the bench's scenarios. These scenarios compare read-back data and exported registers against a bench model.

// File: rtl/evt_regs_pkg.sv
package evt_regs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } bus_st_e;

    localparam int ADDR_W = 10;
    localparam int TIDX_W = 5;

    localparam logic [ADDR_W-1:0] OFF_CAP_LO  = 10'h000;
    localparam logic [ADDR_W-1:0] OFF_CAP_HI  = 10'h004;
    localparam logic [ADDR_W-1:0] OFF_GCFG    = 10'h010;
    localparam logic [ADDR_W-1:0] OFF_GCFG_HI = 10'h014;
    localparam logic [ADDR_W-1:0] OFF_STS     = 10'h020;
    localparam logic [ADDR_W-1:0] OFF_CNT_LO  = 10'h0F0;
    localparam logic [ADDR_W-1:0] OFF_CNT_HI  = 10'h0F4;

    localparam logic [31:0] ID_PATTERN = 32'h8086_A001;
    localparam logic [31:0] TCFG_WMASK = 32'h0000_7F4E;
    localparam logic [31:0] TCFG_RST   = 32'h0000_0030;

endpackage

// File: rtl/evt_main_counter.sv
module evt_main_counter (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    input  logic        rd_lo,
    input  logic        rd_hi,
    output logic [63:0] value,
    output logic [31:0] hi_rdata
);
    logic [31:0] shadow;
    logic        shadow_vld;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (wr_lo) begin
            value <= {value[63:32], wdata};
        end else if (wr_hi) begin
            value <= {wdata, value[31:0]};
        end else if (run) begin
            value <= value + 64'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow     <= '0;
            shadow_vld <= 1'b0;
        end else if (rd_lo) begin
            shadow     <= value[63:32];
            shadow_vld <= 1'b1;
        end else if (rd_hi) begin
            shadow_vld <= 1'b0;
        end
    end

    assign hi_rdata = shadow_vld ? shadow : value[63:32];
endmodule

// File: rtl/evt_status.sv
module evt_status #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] fire,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_data,
    input  logic         flush,
    output logic [N-1:0] status,
    output logic [N-1:0] clr_pulse
);
    assign clr_pulse = clr_wr ? (clr_data & status) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
        end else if (flush) begin
            status <= '0;
        end else begin
            status <= (status & ~clr_pulse) | fire;
        end
    end
endmodule

// File: rtl/evt_timer_bank.sv
module evt_timer_bank
    import evt_regs_pkg::*;
#(
    parameter int N = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [TIDX_W-1:0]      wr_idx,
    input  logic [2:0]             wr_word,
    input  logic [31:0]            wdata,
    output logic [N-1:0][31:0]     cfg,
    output logic [N-1:0][63:0]     cmp,
    output logic [N-1:0][63:0]     route
);
    for (genvar g = 0; g < N; g++) begin : g_tmr
        logic sel;
        assign sel = wr_en && (wr_idx == TIDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg[g]   <= TCFG_RST;
                cmp[g]   <= '1;
                route[g] <= '0;
            end else if (sel) begin
                case (wr_word)
                    3'd0: cfg[g] <= (wdata & TCFG_WMASK) | (cfg[g] & ~TCFG_WMASK);
                    3'd2: cmp[g][31:0]    <= wdata;
                    3'd3: cmp[g][63:32]   <= wdata;
                    3'd4: route[g][31:0]  <= wdata;
                    3'd5: route[g][63:32] <= wdata;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
    import evt_regs_pkg::*;
#(
    parameter int          NUM_TIMERS  = 3,
    parameter logic [31:0] TICK_PERIOD = 32'h05F5_E100,
    parameter logic [31:0] ROUTE_CAP   = 32'h00F0_0000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [9:0]               req_addr,
    input  logic [31:0]              req_wdata,
    output logic                     req_ready,
    output logic                     rsp_valid,
    output logic [31:0]              rsp_rdata,
    input  logic [NUM_TIMERS-1:0]    evt_fire,
    output logic [63:0]              cnt_value,
    output logic                     tmr_enable,
    output logic                     legacy_route,
    output logic [NUM_TIMERS-1:0]    irq_status,
    output logic [NUM_TIMERS-1:0]    status_clr,
    output logic                     cancel_all,
    output logic [NUM_TIMERS*32-1:0] tmr_cfg,
    output logic [NUM_TIMERS*64-1:0] tmr_cmp,
    output logic [NUM_TIMERS*64-1:0] tmr_route
);
    localparam logic [31:0] CAP_LO = ID_PATTERN | (32'(NUM_TIMERS - 1) << 8);

    bus_st_e            state, state_nx;
    logic               lat_wr;
    logic [ADDR_W-1:0]  lat_addr;
    logic [31:0]        lat_wdata;
    logic [1:0]         gcfg;

    logic               aligned, in_tmr, tmr_ok, do_wr, do_rd;
    logic [TIDX_W-1:0]  tidx;
    logic [2:0]         twd;
    logic               gcfg_wr, sts_wr, cnt_lo_wr, cnt_hi_wr, cnt_wr, tmr_wr;
    logic               cnt_lo_rd, cnt_hi_rd;
    logic [31:0]        cnt_hi_rdata;

    logic [NUM_TIMERS-1:0][31:0] cfg_p;
    logic [NUM_TIMERS-1:0][63:0] cmp_p;
    logic [NUM_TIMERS-1:0][63:0] route_p;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid) state_nx = req_write ? ST_WRITE : ST_READ;
            ST_READ:  state_nx = ST_IDLE;
            ST_WRITE: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register and request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            lat_wr    <= 1'b0;
            lat_addr  <= '0;
            lat_wdata <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && req_valid) begin
                lat_wr    <= req_write;
                lat_addr  <= req_addr;
                lat_wdata <= req_wdata;
            end
        end
    end

    // address decode of the latched request
    assign aligned   = (lat_addr[1:0] == 2'b00);
    assign in_tmr    = (lat_addr[9:8] != 2'b00);
    assign tidx      = lat_addr[9:5] - TIDX_W'(8);
    assign twd       = lat_addr[4:2];
    assign tmr_ok    = in_tmr && (tidx < TIDX_W'(NUM_TIMERS));
    assign do_wr     = (state == ST_WRITE) && lat_wr && aligned;
    assign do_rd     = (state == ST_READ) && aligned;
    assign gcfg_wr   = do_wr && (lat_addr == OFF_GCFG);
    assign sts_wr    = do_wr && (lat_addr == OFF_STS);
    assign cnt_lo_wr = do_wr && (lat_addr == OFF_CNT_LO);
    assign cnt_hi_wr = do_wr && (lat_addr == OFF_CNT_HI);
    assign cnt_wr    = cnt_lo_wr || cnt_hi_wr;
    assign tmr_wr    = do_wr && tmr_ok;
    assign cnt_lo_rd = do_rd && (lat_addr == OFF_CNT_LO);
    assign cnt_hi_rd = do_rd && (lat_addr == OFF_CNT_HI);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       gcfg <= 2'b00;
        else if (gcfg_wr) gcfg <= lat_wdata[1:0];
    end

    assign tmr_enable   = gcfg[0];
    assign legacy_route = gcfg[1];
    assign cancel_all   = gcfg_wr && gcfg[0] && !lat_wdata[0];

    evt_main_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (gcfg[0]),
        .wr_lo    (cnt_lo_wr),
        .wr_hi    (cnt_hi_wr),
        .wdata    (lat_wdata),
        .rd_lo    (cnt_lo_rd),
        .rd_hi    (cnt_hi_rd),
        .value    (cnt_value),
        .hi_rdata (cnt_hi_rdata)
    );

    evt_status #(.N(NUM_TIMERS)) u_sts (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (evt_fire),
        .clr_wr    (sts_wr),
        .clr_data  (lat_wdata[NUM_TIMERS-1:0]),
        .flush     (cancel_all),
        .status    (irq_status),
        .clr_pulse (status_clr)
    );

    evt_timer_bank #(.N(NUM_TIMERS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tmr_wr),
        .wr_idx  (tidx),
        .wr_word (twd),
        .wdata   (lat_wdata),
        .cfg     (cfg_p),
        .cmp     (cmp_p),
        .route   (route_p)
    );

    assign tmr_cfg   = cfg_p;
    assign tmr_cmp   = cmp_p;
    assign tmr_route = route_p;

    // outputs: handshake and read data
    always_comb begin
        logic [31:0] s_cfg;
        logic [63:0] s_cmp, s_route;
        s_cfg   = '0;
        s_cmp   = '0;
        s_route = '0;
        for (int k = 0; k < NUM_TIMERS; k++) begin
            if (tidx == TIDX_W'(k)) begin
                s_cfg   = cfg_p[k];
                s_cmp   = cmp_p[k];
                s_route = route_p[k];
            end
        end

        req_ready = (state == ST_IDLE);
        rsp_valid = (state != ST_IDLE);
        rsp_rdata = '0;
        if (do_rd) begin
            if (tmr_ok) begin
                case (twd)
                    3'd0: rsp_rdata = s_cfg;
                    3'd1: rsp_rdata = ROUTE_CAP;
                    3'd2: rsp_rdata = s_cmp[31:0];
                    3'd3: rsp_rdata = s_cmp[63:32];
                    3'd4: rsp_rdata = s_route[31:0];
                    3'd5: rsp_rdata = s_route[63:32];
                    default: rsp_rdata = '0;
                endcase
            end else begin
                case (lat_addr)
                    OFF_CAP_LO: rsp_rdata = CAP_LO;
                    OFF_CAP_HI: rsp_rdata = TICK_PERIOD;
                    OFF_GCFG:   rsp_rdata = {30'd0, gcfg};
                    OFF_STS:    rsp_rdata = 32'(irq_status);
                    OFF_CNT_LO: rsp_rdata = cnt_value[31:0];
                    OFF_CNT_HI: rsp_rdata = cnt_hi_rdata;
                    default:    rsp_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/evt_regs_chk.sv
module evt_regs_chk #(
    parameter int N = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic         req_ready,
    input logic         rsp_valid,
    input logic [63:0]  cnt_value,
    input logic         tmr_enable,
    input logic         cnt_wr,
    input logic [N-1:0] irq_status,
    input logic [N-1:0] status_clr,
    input logic [N-1:0] evt_fire,
    input logic         cancel_all
);
    // R2
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R5
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_enable && !cnt_wr) |=> $stable(cnt_value));

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_enable && !cnt_wr) |=> (cnt_value == $past(cnt_value) + 64'd1));

    // R8
    sts_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|status_clr) |=> ((irq_status & $past(status_clr) & ~$past(evt_fire)) == '0));

    // R9
    cancel_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_all |=> (!tmr_enable && (irq_status == '0)));
endmodule

bind evt_timer_regs evt_regs_chk #(.N(NUM_TIMERS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .cnt_value  (cnt_value),
    .tmr_enable (tmr_enable),
    .cnt_wr     (cnt_wr),
    .irq_status (irq_status),
    .status_clr (status_clr),
    .evt_fire   (evt_fire),
    .cancel_all (cancel_all)
);

// File: tb/evt_timer_regs_test.sv
module evt_timer_regs_test;
    localparam int          CLK_PERIOD = 10;
    localparam int          N          = 3;
    localparam logic [31:0] TICK       = 32'h05F5_E100;
    localparam logic [31:0] RCAP       = 32'h00F0_0000;
    localparam logic [31:0] WMASK      = 32'h0000_7F4E;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [9:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic req_ready, rsp_valid;
    logic [31:0] rsp_rdata;
    logic [N-1:0] evt_fire = '0;
    logic [63:0] cnt_value;
    logic tmr_enable, legacy_route, cancel_all;
    logic [N-1:0] irq_status, status_clr;
    logic [N*32-1:0] tmr_cfg;
    logic [N*64-1:0] tmr_cmp, tmr_route;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_timer_regs #(.NUM_TIMERS(N), .TICK_PERIOD(TICK), .ROUTE_CAP(RCAP)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .evt_fire(evt_fire),
        .cnt_value(cnt_value), .tmr_enable(tmr_enable), .legacy_route(legacy_route),
        .irq_status(irq_status), .status_clr(status_clr), .cancel_all(cancel_all),
        .tmr_cfg(tmr_cfg), .tmr_cmp(tmr_cmp), .tmr_route(tmr_route)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // bench model
    logic [31:0]  m_cfg   [N];
    logic [63:0]  m_cmp   [N];
    logic [63:0]  m_route [N];
    logic [1:0]   m_gcfg;
    logic [N-1:0] m_sts;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [9:0] a);
        int idx;
        if (a[1:0] != 2'b00) return 32'd0;
        case (a)
            10'h000: return 32'h8086_A001 | (32'(N - 1) << 8);
            10'h004: return TICK;
            10'h010: return {30'd0, m_gcfg};
            10'h020: return 32'(m_sts);
            default: ;
        endcase
        if (a < 10'h100) return 32'd0;
        idx = int'(a[9:5]) - 8;
        if (idx >= N) return 32'd0;
        case (a[4:2])
            3'd0: return m_cfg[idx];
            3'd1: return RCAP;
            3'd2: return m_cmp[idx][31:0];
            3'd3: return m_cmp[idx][63:32];
            3'd4: return m_route[idx][31:0];
            3'd5: return m_route[idx][63:32];
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [9:0] a);
        if (a[1:0] != 2'b00) return "R1";
        if (a == 10'h000 || a == 10'h004) return "R3";
        if (a == 10'h010) return "R4";
        if (a == 10'h020) return "R8";
        if (a < 10'h100) return "R1";
        if (int'(a[9:5]) - 8 >= N) return "R11";
        return "R10";
    endfunction

    task automatic model_wr(input logic [9:0] a, input logic [31:0] d);
        int idx;
        if (a[1:0] != 2'b00) return;
        if (a == 10'h010) begin
            if (m_gcfg[0] && !d[0]) m_sts = '0;
            m_gcfg = d[1:0];
            return;
        end
        if (a == 10'h020) begin
            m_sts = m_sts & ~d[N-1:0];
            return;
        end
        if (a < 10'h100) return;
        idx = int'(a[9:5]) - 8;
        if (idx >= N) return;
        case (a[4:2])
            3'd0: m_cfg[idx] = (d & WMASK) | (m_cfg[idx] & ~WMASK);
            3'd2: m_cmp[idx][31:0]    = d;
            3'd3: m_cmp[idx][63:32]   = d;
            3'd4: m_route[idx][31:0]  = d;
            3'd5: m_route[idx][63:32] = d;
            default: ;
        endcase
    endtask

    task automatic bus_rd(input logic [9:0] a, output logic [31:0] d, output int stamp);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rsp_rdata;
        stamp = cyc;
        check("R2 rsp_valid on read", {63'd0, rsp_valid}, 64'd1);
    endtask

    task automatic bus_wr(input logic [9:0] a, input logic [31:0] d,
                          output logic [N-1:0] clr_seen, output logic canc_seen);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        clr_seen  = status_clr;
        canc_seen = cancel_all;
        check("R2 rsp_valid on write", {63'd0, rsp_valid}, 64'd1);
    endtask

    task automatic fire(input logic [N-1:0] b);
        @(negedge clk);
        evt_fire = b;
        @(negedge clk);
        evt_fire = '0;
        m_sts = m_sts | b;
    endtask

    task automatic check_ports();
        for (int k = 0; k < N; k++) begin
            check("R10 tmr_cfg port", {32'd0, tmr_cfg[k*32 +: 32]}, {32'd0, m_cfg[k]});
            check("R10 tmr_cmp port", tmr_cmp[k*64 +: 64], m_cmp[k]);
            check("R10 tmr_route port", tmr_route[k*64 +: 64], m_route[k]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, v1, v2;
        logic [N-1:0] clr;
        logic canc;
        int t1, t2;
        logic [9:0] a;
        logic [31:0] w;
        void'($urandom(32'd2024));

        for (int k = 0; k < N; k++) begin
            m_cfg[k] = 32'h30; m_cmp[k] = '1; m_route[k] = '0;
        end
        m_gcfg = 2'b00;
        m_sts = '0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // reset state
        check("R2 ready at reset", {63'd0, req_ready}, 64'd1);
        check("R5 counter reset", cnt_value, 64'd0);
        check("R4 enable reset", {62'd0, legacy_route, tmr_enable}, 64'd0);
        check_ports();
        for (int i = 0; i < 4; i++) begin
            a = 10'h100 + 10'(i * 32);
            for (int wd = 0; wd < 8; wd++) begin
                bus_rd(a + 10'(wd * 4), d, t1);
                check({tag_of(a), " reset read"}, {32'd0, d}, {32'd0, exp_rd(a + 10'(wd * 4))});
            end
        end

        // capability: contents and ignored writes
        bus_rd(10'h000, d, t1);
        check("R3 cap low", {32'd0, d}, 64'h8086_A201);
        bus_wr(10'h000, 32'h0, clr, canc);
        bus_wr(10'h004, 32'h1234, clr, canc);
        bus_rd(10'h000, d, t1);
        check("R3 cap low after write", {32'd0, d}, 64'h8086_A201);
        bus_rd(10'h004, d, t1);
        check("R3 tick period", {32'd0, d}, {32'd0, TICK});

        // global config mask and the unused upper word
        bus_wr(10'h010, 32'hFFFF_FFFE, clr, canc);
        model_wr(10'h010, 32'hFFFF_FFFE);
        bus_rd(10'h010, d, t1);
        check("R4 gcfg masked", {32'd0, d}, 64'h2);
        check("R4 legacy port", {63'd0, legacy_route}, 64'd1);
        bus_wr(10'h014, 32'hFFFF_FFFF, clr, canc);
        bus_rd(10'h014, d, t1);
        check("R1 gcfg upper reads zero", {32'd0, d}, 64'd0);

        // counter frozen while disabled, written in halves
        bus_wr(10'h0F0, 32'hFFFF_FFFE, clr, canc);
        bus_wr(10'h0F4, 32'h5, clr, canc);
        repeat (10) @(posedge clk);
        bus_rd(10'h0F0, d, t1);
        check("R6 low half written", {32'd0, d}, 64'hFFFF_FFFE);
        bus_rd(10'h0F4, d, t1);
        check("R6 high half written", {32'd0, d}, 64'h5);
        check("R5 frozen counter", cnt_value, 64'h5_FFFF_FFFE);

        // counting rate while enabled
        bus_wr(10'h010, 32'h1, clr, canc);
        model_wr(10'h010, 32'h1);
        bus_rd(10'h0F0, v1, t1);
        repeat (7) @(posedge clk);
        bus_rd(10'h0F0, v2, t2);
        check("R5 advance per clock", {32'd0, v2 - v1}, 64'(t2 - t1));

        // write while enabled, then shadow across a wrap
        bus_wr(10'h0F4, 32'h7, clr, canc);
        bus_wr(10'h0F0, 32'hFFFF_FFC0, clr, canc);
        bus_rd(10'h0F0, v1, t1);
        check("R6 write while enabled", {63'd0, (v1 - 32'hFFFF_FFC0) < 32'd8}, 64'd1);
        repeat (100) @(posedge clk);
        bus_rd(10'h0F4, d, t1);
        check("R7 shadow high after wrap", {32'd0, d}, 64'h7);
        bus_rd(10'h0F4, d, t1);
        check("R7 live high after release", {32'd0, d}, 64'h8);

        // status: set, W1C only over set bits, set wins over clear
        fire(3'b101);
        bus_rd(10'h020, d, t1);
        check("R8 status set", {32'd0, d}, 64'h5);
        bus_wr(10'h020, 32'hFFFF_FFFE, clr, canc);
        model_wr(10'h020, 32'hFFFF_FFFE);
        check("R8 clear pulse", {61'd0, clr}, 64'h4);
        bus_rd(10'h020, d, t1);
        check("R8 status after clear", {32'd0, d}, 64'h1);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 10'h020; req_wdata = 32'h1;
        @(negedge clk);
        req_valid = 1'b0;
        evt_fire = 3'b001;
        @(negedge clk);
        evt_fire = '0;
        bus_rd(10'h020, d, t1);
        check("R8 set wins over clear", {32'd0, d}, 64'h1);

        // disable: cancel pulse, status flush, frozen counter
        fire(3'b110);
        bus_wr(10'h010, 32'h0, clr, canc);
        m_sts = '0;
        m_gcfg = 2'b00;
        check("R9 cancel pulse", {63'd0, canc}, 64'd1);
        bus_rd(10'h020, d, t1);
        check("R9 status flushed", {32'd0, d}, 64'd0);
        bus_rd(10'h0F0, v1, t1);
        repeat (9) @(posedge clk);
        bus_rd(10'h0F0, v2, t2);
        check("R5 held after disable", {32'd0, v2}, {32'd0, v1});

        // constrained random traffic against the model
        for (int it = 0; it < 500; it++) begin
            int cls;
            cls = int'($urandom % 10);
            if (cls <= 4) begin
                a = 10'h100 + 10'(($urandom % 5) * 32) + 10'(($urandom % 8) * 4);
                if ($urandom % 8 == 0) a = a | 10'(1 + $urandom % 3);
            end else if (cls == 5) begin
                case ($urandom % 4)
                    0: a = 10'h000;
                    1: a = 10'h004;
                    2: a = 10'h010;
                    default: a = 10'h014;
                endcase
            end else if (cls == 6) begin
                a = 10'h020;
            end else if (cls == 8) begin
                a = 10'h030 + 10'(($urandom % 48) * 4);
            end else begin
                a = 10'h3FF;
            end

            if (cls == 7) begin
                fire(N'($urandom));
            end else if ($urandom % 2 == 0) begin
                w = $urandom;
                if (a == 10'h020 || a == 10'h010) begin
                    logic [N-1:0] exp_clr;
                    logic exp_canc;
                    exp_clr  = (a == 10'h020) ? (m_sts & w[N-1:0]) : '0;
                    exp_canc = (a == 10'h010) && m_gcfg[0] && !w[0];
                    bus_wr(a, w, clr, canc);
                    check("R8 random clear pulse", {61'd0, clr}, {61'd0, exp_clr});
                    check("R9 random cancel", {63'd0, canc}, {63'd0, exp_canc});
                end else begin
                    bus_wr(a, w, clr, canc);
                end
                model_wr(a, w);
                bus_rd(a, d, t1);
                check({tag_of(a), " readback"}, {32'd0, d}, {32'd0, exp_rd(a)});
                check_ports();
            end else begin
                bus_rd(a, d, t1);
                check({tag_of(a), " read"}, {32'd0, d}, {32'd0, exp_rd(a)});
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule